// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block carries the software-interrupt path of an interrupt distributor serving up to eight CPUs and sixteen software interrupt numbers. A CPU raises a software interrupt by writing a 32-bit trigger word that names the interrupt number, a filter mode and an 8-bit list of destination CPUs. Every destination CPU that is online records the sender in a per-interrupt source mask. The pending flag for that CPU and interrupt is simply whether the mask is nonzero.

A second access port opens two 16-byte windows onto the source masks of any chosen CPU, one byte per interrupt number. Writes to the set window add sender bits and writes to the clear window remove them. Byte and 32-bit accesses are both accepted. Reads return the mask bytes, one cycle after the read strobe. The per-CPU, per-interrupt pending flags leave the block as one flat vector for the downstream priority logic.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset every source mask is zero, every bit of `pend_o` is low and `acc_rdata_o` is zero.
- R2: A trigger word takes the interrupt number from bits [3:0], the destination list from bits [23:16] and the filter mode from bits [25:24]. In mode 0 the destinations are exactly the listed CPUs.
- R3: In mode 1 the destinations are all online CPUs other than the sender, and the list field is ignored.
- R4: In mode 2 the only destination is the sender, and the list field is ignored.
- R5: A trigger word in mode 3 changes no state.
- R6: For each destination CPU c, the trigger ORs bit `trig_src_i` into the mask of (c, interrupt). The bit `pend_o[c*16+id]` is high exactly when that mask is nonzero, starting the cycle after the write.
- R7: A CPU whose index is greater than or equal to `online_cnt_i` is never a trigger destination, whatever the list or mode selects.
- R8: `acc_sel_i` decodes as 0 = trigger register, 1 = set window, 2 = clear window, 3 = unmapped. A write to the set window ORs each written byte into the mask of the addressed interrupt on CPU `acc_cpu_i`.
- R9: A write to the clear window removes the written bits from the mask. The pending flag drops when the mask reaches zero.
- R10: With `acc_word_i` = 0, the access covers one byte (lane 0, bits [7:0]) at interrupt `acc_addr_i`. With `acc_word_i` = 1, lane i (bits [8i+7:8i]) covers interrupt `acc_addr_i`+i. Lanes beyond interrupt 15 are dropped on writes and read as zero.
- R11: A read updates `acc_rdata_o` on the next clock, using the state before any write in the same cycle. Both windows return the mask bytes. The trigger register and unmapped space return zero. Without a read, `acc_rdata_o` holds its value.
- R12: When a trigger and a clear-window write hit the same CPU and interrupt in one cycle, the clear is applied first and the sender bit is set afterwards.
- R13: Writes on the access port with `acc_sel_i` 0 or 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| online_cnt_i | input | 4 | Number of online CPUs (0..8) |
| trig_we_i | input | 1 | Trigger word write strobe |
| trig_src_i | input | 3 | Index of the CPU issuing the trigger |
| trig_data_i | input | 32 | Trigger word |
| acc_we_i | input | 1 | Access-port write strobe |
| acc_re_i | input | 1 | Access-port read strobe |
| acc_sel_i | input | 2 | Region select: 0 trigger, 1 set, 2 clear, 3 unmapped |
| acc_cpu_i | input | 3 | CPU whose masks are accessed |
| acc_addr_i | input | 4 | Byte offset in the window, which is the first interrupt number |
| acc_word_i | input | 1 | 0 = byte access, 1 = 32-bit access |
| acc_wdata_i | input | 32 | Write data |
| acc_rdata_o | output | 32 | Registered read data |
| pend_o | output | 128 | Pending flags, bit c*16+id for CPU c and interrupt id |

## Verification
A corrupted source mask shows at the ports in two ways. If it wrongly reaches or leaves zero, the matching bit of `pend_o` is wrong on the very next cycle. Any other wrong bit stays invisible until that CPU's window is read, so the bench reads the windows often and compares `acc_rdata_o` one cycle after each read. A wrong destination decode, such as a missed online limit or a sender not excluded, shows as a stray or missing pending bit one cycle after the trigger. A wrong ordering of a simultaneous clear and trigger is only visible when both hit the same mask, so that case is driven on purpose.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  typedef enum logic [1:0] {
    MODE_LIST   = 2'd0,
    MODE_OTHERS = 2'd1,
    MODE_SELF   = 2'd2,
    MODE_RSVD   = 2'd3
  } tgt_mode_e;

  typedef enum logic [1:0] {
    SEL_TRIG = 2'd0,
    SEL_SET  = 2'd1,
    SEL_CLR  = 2'd2,
    SEL_NONE = 2'd3
  } acc_sel_e;

  localparam int unsigned TRIG_ID_LSB   = 0;
  localparam int unsigned TRIG_LIST_LSB = 16;
  localparam int unsigned TRIG_MODE_LSB = 24;
  localparam int unsigned LANE_W        = 8;
endpackage

// File: rtl/sgi_target_decode.sv
module sgi_target_decode
  import sgi_pkg::*;
#(
  parameter int unsigned NUM_CPUS = 8,
  localparam int unsigned CPU_W = $clog2(NUM_CPUS),
  localparam int unsigned CNT_W = CPU_W + 1
) (
  input  logic                valid_i,
  input  logic [CPU_W-1:0]    src_i,
  input  logic [NUM_CPUS-1:0] list_i,
  input  tgt_mode_e           mode_i,
  input  logic [CNT_W-1:0]    online_cnt_i,
  output logic [NUM_CPUS-1:0] hit_o
);
  logic [NUM_CPUS-1:0] online_mask;
  logic [NUM_CPUS-1:0] self_mask;
  logic [NUM_CPUS-1:0] raw;

  for (genvar g = 0; g < NUM_CPUS; g++) begin : g_online
    assign online_mask[g] = online_cnt_i > CNT_W'(g);
  end

  always_comb begin
    self_mask = '0;
    self_mask[src_i] = 1'b1;
    unique case (mode_i)
      MODE_LIST:   raw = list_i;
      MODE_OTHERS: raw = ~self_mask;
      MODE_SELF:   raw = self_mask;
      default:     raw = '0;
    endcase
    hit_o = valid_i ? (raw & online_mask) : '0;
  end
endmodule

// File: rtl/sgi_lane_decode.sv
module sgi_lane_decode
  import sgi_pkg::*;
#(
  parameter int unsigned NUM_IDS = 16,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned ID_W  = $clog2(NUM_IDS),
  localparam int unsigned IDX_W = ID_W + 1,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic                            we_i,
  input  acc_sel_e                        sel_i,
  input  logic [ID_W-1:0]                 addr_i,
  input  logic                            word_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [NUM_IDS-1:0]              set_en_o,
  output logic [NUM_IDS-1:0]              clr_en_o,
  output logic [NUM_IDS-1:0][LANE_W-1:0]  byte_o
);
  logic [NUM_IDS-1:0] lane_en;
  logic [IDX_W-1:0]   idx;

  always_comb begin
    lane_en = '0;
    byte_o  = '0;
    idx     = '0;
    for (int l = 0; l < LANES; l++) begin
      idx = {1'b0, addr_i} + IDX_W'(l);
      if ((l == 0 || word_i) && idx < IDX_W'(NUM_IDS)) begin
        lane_en[idx[ID_W-1:0]] = 1'b1;
        byte_o[idx[ID_W-1:0]]  = wdata_i[l*LANE_W +: LANE_W];
      end
    end
    set_en_o = (we_i && sel_i == SEL_SET) ? lane_en : '0;
    clr_en_o = (we_i && sel_i == SEL_CLR) ? lane_en : '0;
  end
endmodule

// File: rtl/sgi_src_bank.sv
module sgi_src_bank
  import sgi_pkg::*;
#(
  parameter int unsigned NUM_CPUS = 8,
  parameter int unsigned NUM_IDS  = 16,
  localparam int unsigned CPU_W = $clog2(NUM_CPUS),
  localparam int unsigned ID_W  = $clog2(NUM_IDS)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               trig_hit_i,
  input  logic [ID_W-1:0]                    trig_id_i,
  input  logic [CPU_W-1:0]                   trig_src_i,
  input  logic                               win_hit_i,
  input  logic [NUM_IDS-1:0]                 set_en_i,
  input  logic [NUM_IDS-1:0]                 clr_en_i,
  input  logic [NUM_IDS-1:0][LANE_W-1:0]     byte_i,
  output logic [NUM_IDS-1:0][NUM_CPUS-1:0]   mask_o,
  output logic [NUM_IDS-1:0]                 pend_o
);
  logic [NUM_CPUS-1:0] src_oh;

  always_comb begin
    src_oh = '0;
    src_oh[trig_src_i] = 1'b1;
  end

  for (genvar k = 0; k < NUM_IDS; k++) begin : g_id
    logic [NUM_CPUS-1:0] mask_q, mask_d;

    // clear before trigger so a same-cycle trigger survives
    always_comb begin
      mask_d = mask_q;
      if (win_hit_i && clr_en_i[k]) mask_d = mask_d & ~byte_i[k][NUM_CPUS-1:0];
      if (win_hit_i && set_en_i[k]) mask_d = mask_d | byte_i[k][NUM_CPUS-1:0];
      if (trig_hit_i && trig_id_i == ID_W'(k)) mask_d = mask_d | src_oh;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_q <= '0;
      else         mask_q <= mask_d;
    end

    assign mask_o[k] = mask_q;
    assign pend_o[k] = |mask_q;
  end
endmodule

// File: rtl/sgi_read_port.sv
module sgi_read_port
  import sgi_pkg::*;
#(
  parameter int unsigned NUM_CPUS = 8,
  parameter int unsigned NUM_IDS  = 16,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned CPU_W = $clog2(NUM_CPUS),
  localparam int unsigned ID_W  = $clog2(NUM_IDS),
  localparam int unsigned IDX_W = ID_W + 1,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic                                            clk_i,
  input  logic                                            rst_ni,
  input  logic                                            re_i,
  input  acc_sel_e                                        sel_i,
  input  logic [CPU_W-1:0]                                cpu_i,
  input  logic [ID_W-1:0]                                 addr_i,
  input  logic                                            word_i,
  input  logic [NUM_CPUS-1:0][NUM_IDS-1:0][NUM_CPUS-1:0]  masks_i,
  output logic [DATA_W-1:0]                               rdata_o
);
  logic [DATA_W-1:0] word_d;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    word_d = '0;
    idx    = '0;
    if (sel_i == SEL_SET || sel_i == SEL_CLR) begin
      for (int l = 0; l < LANES; l++) begin
        idx = {1'b0, addr_i} + IDX_W'(l);
        if ((l == 0 || word_i) && idx < IDX_W'(NUM_IDS))
          word_d[l*LANE_W +: NUM_CPUS] = masks_i[cpu_i][idx[ID_W-1:0]];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= word_d;
  end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int unsigned NUM_CPUS = 8,
  parameter int unsigned NUM_IDS  = 16,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned CPU_W = $clog2(NUM_CPUS),
  localparam int unsigned CNT_W = CPU_W + 1,
  localparam int unsigned ID_W  = $clog2(NUM_IDS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [CNT_W-1:0]             online_cnt_i,
  input  logic                         trig_we_i,
  input  logic [CPU_W-1:0]             trig_src_i,
  input  logic [DATA_W-1:0]            trig_data_i,
  input  logic                         acc_we_i,
  input  logic                         acc_re_i,
  input  logic [1:0]                   acc_sel_i,
  input  logic [CPU_W-1:0]             acc_cpu_i,
  input  logic [ID_W-1:0]              acc_addr_i,
  input  logic                         acc_word_i,
  input  logic [DATA_W-1:0]            acc_wdata_i,
  output logic [DATA_W-1:0]            acc_rdata_o,
  output logic [NUM_CPUS*NUM_IDS-1:0]  pend_o
);
  logic [ID_W-1:0]                              trig_id;
  logic [NUM_CPUS-1:0]                          trig_list;
  tgt_mode_e                                    trig_mode;
  acc_sel_e                                     sel;
  logic [NUM_CPUS-1:0]                          trig_hit;
  logic [NUM_IDS-1:0]                           set_en, clr_en;
  logic [NUM_IDS-1:0][LANE_W-1:0]               wr_byte;
  logic [NUM_CPUS-1:0][NUM_IDS-1:0][NUM_CPUS-1:0] masks;
  logic [NUM_CPUS-1:0][NUM_IDS-1:0]             pend_c;

  assign trig_id   = trig_data_i[TRIG_ID_LSB +: ID_W];
  assign trig_list = trig_data_i[TRIG_LIST_LSB +: NUM_CPUS];
  assign trig_mode = tgt_mode_e'(trig_data_i[TRIG_MODE_LSB +: 2]);
  assign sel       = acc_sel_e'(acc_sel_i);

  sgi_target_decode #(.NUM_CPUS(NUM_CPUS)) u_tgt (
    .valid_i      (trig_we_i),
    .src_i        (trig_src_i),
    .list_i       (trig_list),
    .mode_i       (trig_mode),
    .online_cnt_i (online_cnt_i),
    .hit_o        (trig_hit)
  );

  sgi_lane_decode #(.NUM_IDS(NUM_IDS), .DATA_W(DATA_W)) u_lane (
    .we_i     (acc_we_i),
    .sel_i    (sel),
    .addr_i   (acc_addr_i),
    .word_i   (acc_word_i),
    .wdata_i  (acc_wdata_i),
    .set_en_o (set_en),
    .clr_en_o (clr_en),
    .byte_o   (wr_byte)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    sgi_src_bank #(.NUM_CPUS(NUM_CPUS), .NUM_IDS(NUM_IDS)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .trig_hit_i (trig_hit[c]),
      .trig_id_i  (trig_id),
      .trig_src_i (trig_src_i),
      .win_hit_i  (acc_cpu_i == CPU_W'(c)),
      .set_en_i   (set_en),
      .clr_en_i   (clr_en),
      .byte_i     (wr_byte),
      .mask_o     (masks[c]),
      .pend_o     (pend_c[c])
    );
    assign pend_o[c*NUM_IDS +: NUM_IDS] = pend_c[c];
  end

  sgi_read_port #(.NUM_CPUS(NUM_CPUS), .NUM_IDS(NUM_IDS), .DATA_W(DATA_W)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .re_i    (acc_re_i),
    .sel_i   (sel),
    .cpu_i   (acc_cpu_i),
    .addr_i  (acc_addr_i),
    .word_i  (acc_word_i),
    .masks_i (masks),
    .rdata_o (acc_rdata_o)
  );
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
  parameter int unsigned NUM_CPUS = 8,
  parameter int unsigned NUM_IDS  = 16,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned CPU_W = $clog2(NUM_CPUS),
  localparam int unsigned CNT_W = CPU_W + 1,
  localparam int unsigned ID_W  = $clog2(NUM_IDS),
  localparam int unsigned PW    = $clog2(NUM_CPUS*NUM_IDS)
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [CNT_W-1:0]             online_cnt_i,
  input logic                         trig_we_i,
  input logic [CPU_W-1:0]             trig_src_i,
  input logic [DATA_W-1:0]            trig_data_i,
  input logic                         acc_we_i,
  input logic                         acc_re_i,
  input logic [1:0]                   acc_sel_i,
  input logic [CPU_W-1:0]             acc_cpu_i,
  input logic [ID_W-1:0]              acc_addr_i,
  input logic                         acc_word_i,
  input logic [DATA_W-1:0]            acc_wdata_i,
  input logic [DATA_W-1:0]            acc_rdata_o,
  input logic [NUM_CPUS*NUM_IDS-1:0]  pend_o
);
  logic [PW-1:0]       self_idx, win_idx;
  logic [1:0]          mode;
  logic [NUM_CPUS-1:0] online_mask;

  assign mode     = trig_data_i[25:24];
  assign self_idx = PW'(trig_src_i) * PW'(NUM_IDS) + PW'(trig_data_i[ID_W-1:0]);
  assign win_idx  = PW'(acc_cpu_i) * PW'(NUM_IDS) + PW'(acc_addr_i);

  for (genvar g = 0; g < NUM_CPUS; g++) begin : g_on
    assign online_mask[g] = online_cnt_i > CNT_W'(g);
  end

  // R4
  self_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_we_i && mode == 2'd2 && CNT_W'(trig_src_i) < online_cnt_i |=> pend_o[$past(self_idx)]);

  // R3
  others_skip_self_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_we_i && mode == 2'd1 && !acc_we_i |=> pend_o[$past(self_idx)] == $past(pend_o[self_idx]));

  // R5
  rsvd_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_we_i && mode == 2'd3 && !acc_we_i |=> $stable(pend_o));

  // R7
  offline_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_we_i && mode == 2'd0 && (trig_data_i[16 +: NUM_CPUS] & online_mask) == '0 && !acc_we_i
    |=> $stable(pend_o));

  // R9
  clear_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_we_i && acc_sel_i == 2'd2 && !acc_word_i && acc_wdata_i[7:0] == 8'hFF && !trig_we_i
    |=> !pend_o[$past(win_idx)]);

  // R11
  raz_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_re_i && (acc_sel_i == 2'd0 || acc_sel_i == 2'd3) |=> acc_rdata_o == '0);

  // R11
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_re_i |=> $stable(acc_rdata_o));

  // R13
  dead_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_we_i && (acc_sel_i == 2'd0 || acc_sel_i == 2'd3) && !trig_we_i |=> $stable(pend_o));
endmodule

bind sgi_dispatch sgi_dispatch_chk #(
  .NUM_CPUS(NUM_CPUS), .NUM_IDS(NUM_IDS), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/sgi_dispatch_test.sv
module sgi_dispatch_test;
  localparam int NC = 8;
  localparam int NI = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [3:0]   online_cnt_i = 4'd8;
  logic         trig_we_i = 1'b0;
  logic [2:0]   trig_src_i = '0;
  logic [31:0]  trig_data_i = '0;
  logic         acc_we_i = 1'b0;
  logic         acc_re_i = 1'b0;
  logic [1:0]   acc_sel_i = '0;
  logic [2:0]   acc_cpu_i = '0;
  logic [3:0]   acc_addr_i = '0;
  logic         acc_word_i = 1'b0;
  logic [31:0]  acc_wdata_i = '0;
  logic [31:0]  acc_rdata_o;
  logic [127:0] pend_o;

  int total = 0;
  int bad = 0;
  string cur_tag = "R1";
  string exp_tag = "R1";

  logic [7:0]  m [NC][NI];
  logic [31:0] exp_rd = '0;

  always #4 clk_i = ~clk_i;

  sgi_dispatch uut (.*);

  function automatic logic [31:0] model_read();
    logic [31:0] w = '0;
    if (acc_sel_i == 2'd1 || acc_sel_i == 2'd2)
      for (int l = 0; l < 4; l++)
        if ((l == 0 || acc_word_i) && int'(acc_addr_i) + l < NI)
          w[l*8 +: 8] = m[acc_cpu_i][int'(acc_addr_i) + l];
    return w;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NC; c++) for (int i = 0; i < NI; i++) m[c][i] = '0;
      exp_rd = '0;
      exp_tag = "R1";
    end else begin
      logic [7:0] tgt;
      int id;
      exp_tag = cur_tag;
      if (acc_re_i) exp_rd = model_read();
      if (acc_we_i && (acc_sel_i == 2'd1 || acc_sel_i == 2'd2))
        for (int l = 0; l < 4; l++) begin
          id = int'(acc_addr_i) + l;
          if ((l == 0 || acc_word_i) && id < NI) begin
            if (acc_sel_i == 2'd2) m[acc_cpu_i][id] = m[acc_cpu_i][id] & ~acc_wdata_i[l*8 +: 8];
            else                   m[acc_cpu_i][id] = m[acc_cpu_i][id] | acc_wdata_i[l*8 +: 8];
          end
        end
      if (trig_we_i) begin
        id = int'(trig_data_i[3:0]);
        case (trig_data_i[25:24])
          2'd0: tgt = trig_data_i[23:16];
          2'd1: tgt = 8'hFF & ~(8'h1 << trig_src_i);
          2'd2: tgt = 8'h1 << trig_src_i;
          default: tgt = 8'h00;
        endcase
        for (int c = 0; c < NC; c++)
          if (tgt[c] && c < int'(online_cnt_i)) m[c][id] = m[c][id] | (8'h1 << trig_src_i);
      end
    end
  end

  always @(negedge clk_i) begin
    logic [127:0] ep;
    for (int c = 0; c < NC; c++) for (int i = 0; i < NI; i++) ep[c*NI+i] = |m[c][i];
    total++;
    if (pend_o !== ep) begin
      bad++;
      $display("FAIL %s pend_o actual=%h expected=%h", exp_tag, pend_o, ep);
    end
    total++;
    if (acc_rdata_o !== exp_rd) begin
      bad++;
      $display("FAIL %s acc_rdata_o actual=%h expected=%h", exp_tag, acc_rdata_o, exp_rd);
    end
  end

  task automatic idle(input string tag);
    cur_tag = tag;
    trig_we_i = 1'b0; acc_we_i = 1'b0; acc_re_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic trig(input logic [2:0] src, input logic [3:0] id, input logic [7:0] list,
                      input logic [1:0] mode, input string tag);
    cur_tag = tag;
    trig_we_i = 1'b1; trig_src_i = src;
    trig_data_i = {6'h2A, mode, list, 12'hABC, id};
    acc_we_i = 1'b0; acc_re_i = 1'b0;
    @(negedge clk_i);
    trig_we_i = 1'b0;
  endtask

  task automatic acc(input logic we, input logic re, input logic [1:0] sel, input logic [2:0] cpu,
                     input logic [3:0] addr, input logic word, input logic [31:0] d, input string tag);
    cur_tag = tag;
    trig_we_i = 1'b0;
    acc_we_i = we; acc_re_i = re; acc_sel_i = sel; acc_cpu_i = cpu;
    acc_addr_i = addr; acc_word_i = word; acc_wdata_i = d;
    @(negedge clk_i);
    acc_we_i = 1'b0; acc_re_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    idle("R1");
    // R2: list mode, cpus 1 and 3, id 5
    trig(3'd0, 4'd5, 8'h0A, 2'd0, "R2");
    idle("R6");
    acc(1'b0, 1'b1, 2'd1, 3'd1, 4'd4, 1'b1, '0, "R11");
    idle("R11");
    // R3: all but sender
    trig(3'd2, 4'd3, 8'h00, 2'd1, "R3");
    acc(1'b0, 1'b1, 2'd2, 3'd2, 4'd3, 1'b0, '0, "R3");
    acc(1'b0, 1'b1, 2'd1, 3'd7, 4'd0, 1'b1, '0, "R3");
    // R4: sender only
    trig(3'd6, 4'd15, 8'h81, 2'd2, "R4");
    acc(1'b0, 1'b1, 2'd1, 3'd6, 4'd12, 1'b1, '0, "R4");
    // R5: reserved mode dropped
    trig(3'd4, 4'd9, 8'hFF, 2'd3, "R5");
    idle("R5");
    // R7: only 4 cpus online
    online_cnt_i = 4'd4;
    trig(3'd0, 4'd7, 8'hF0, 2'd0, "R7");
    trig(3'd1, 4'd8, 8'h00, 2'd1, "R7");
    trig(3'd5, 4'd2, 8'h00, 2'd2, "R7");
    acc(1'b0, 1'b1, 2'd1, 3'd0, 4'd7, 1'b1, '0, "R7");
    online_cnt_i = 4'd8;
    // R8 / R10: set window writes
    acc(1'b1, 1'b0, 2'd1, 3'd4, 4'd2, 1'b0, 32'hEEEE_EE81, "R8");
    acc(1'b0, 1'b1, 2'd1, 3'd4, 4'd1, 1'b1, '0, "R10");
    acc(1'b1, 1'b0, 2'd1, 3'd7, 4'd14, 1'b1, 32'h4433_2211, "R10");
    acc(1'b0, 1'b1, 2'd2, 3'd7, 4'd13, 1'b1, '0, "R10");
    acc(1'b0, 1'b1, 2'd1, 3'd7, 4'd15, 1'b0, '0, "R10");
    // R9: partial then full clear
    acc(1'b1, 1'b0, 2'd2, 3'd4, 4'd2, 1'b0, 32'h0000_0001, "R9");
    acc(1'b0, 1'b1, 2'd1, 3'd4, 4'd2, 1'b0, '0, "R9");
    acc(1'b1, 1'b0, 2'd2, 3'd4, 4'd2, 1'b0, 32'h0000_0080, "R9");
    acc(1'b1, 1'b0, 2'd2, 3'd1, 4'd4, 1'b1, 32'hFFFF_FFFF, "R9");
    // R11 / R13: trigger and unmapped reads, dead writes
    acc(1'b0, 1'b1, 2'd0, 3'd3, 4'd4, 1'b1, '0, "R11");
    acc(1'b1, 1'b1, 2'd3, 3'd3, 4'd0, 1'b1, 32'hFFFF_FFFF, "R13");
    acc(1'b1, 1'b0, 2'd0, 3'd3, 4'd5, 1'b1, 32'hFFFF_FFFF, "R13");
    // R11: read and write in same cycle returns old value
    acc(1'b1, 1'b1, 2'd1, 3'd5, 4'd0, 1'b1, 32'h0102_0408, "R11");
    acc(1'b0, 1'b1, 2'd1, 3'd5, 4'd0, 1'b1, '0, "R11");
    // R12: trigger and clear collide on cpu 2 id 6
    acc(1'b1, 1'b0, 2'd1, 3'd2, 4'd6, 1'b0, 32'h0000_00F0, "R12");
    cur_tag = "R12";
    trig_we_i = 1'b1; trig_src_i = 3'd3; trig_data_i = {6'h0, 2'd0, 8'h04, 12'h0, 4'd6};
    acc_we_i = 1'b1; acc_sel_i = 2'd2; acc_cpu_i = 3'd2; acc_addr_i = 4'd6;
    acc_word_i = 1'b0; acc_wdata_i = 32'h0000_00FF;
    @(negedge clk_i);
    trig_we_i = 1'b0; acc_we_i = 1'b0;
    acc(1'b0, 1'b1, 2'd2, 3'd2, 4'd6, 1'b0, '0, "R12");
    // R6: mixed traffic
    for (int n = 0; n < 400; n++) begin
      cur_tag = "R6";
      online_cnt_i = 4'($urandom_range(8, 1));
      trig_we_i = 1'($urandom);
      trig_src_i = 3'($urandom);
      trig_data_i = $urandom;
      acc_we_i = 1'($urandom);
      acc_re_i = 1'($urandom);
      acc_sel_i = 2'($urandom);
      acc_cpu_i = 3'($urandom);
      acc_addr_i = 4'($urandom);
      acc_word_i = 1'($urandom);
      acc_wdata_i = $urandom & $urandom;
      @(negedge clk_i);
    end
    idle("R6");
    idle("R6");
    finish_run();
  end
endmodule